// File: doc/BRIEF.md
# Frame Sync Guard and Lock Detector

This block sits behind a channel-bit demodulator and keeps a master frame counter in step with the frame structure. Its input is a stream of sync-pattern detect pulses, one possible pulse per bit period, where a bit period is marked by a one-cycle enable. A position counter runs freely from 0 to FRAME_LEN-1 and marks where the next sync is expected. A detected sync may move the counter only under two conditions. The first is that it lands close to the expected position. The second is that it arrives almost exactly one frame after the sync pattern before it. Any other sync is treated as a false pattern inside the data and is dropped.

A lock flag tracks the coincidence test with asymmetric hysteresis. One coincidence sets it. It clears only after a long run of frame boundaries passes with no coincidence. Downstream logic uses `frame_start` to delimit frames, `locked` to qualify the data, and `realign` to count phase corrections.

Top module: `frame_sync_guard`

## Requirements
- R1: With no accepted sync, the position counter advances once per enabled bit period and wraps after FRAME_LEN (default 588) periods. Each enabled period at position 0 raises `frame_start` for one clock in the cycle after that period's enable edge. Position 0 is the first enabled period after reset.
- R2: Clocks with `bit_en` low change nothing. No strobe is raised, and `sync_det` is ignored in those clocks.
- R3: A sync in an enabled period whose position lies within WIN_TOL (default 6) of position 0 is accepted. The distance is measured modulo FRAME_LEN, so positions 0..6 and FRAME_LEN-6..FRAME_LEN-1 qualify. That period becomes position 0 and raises `frame_start`.
- R4: A sync that arrives FRAME_LEN±COIN_TOL (default ±1) enabled periods after the previous detected sync is a coincidence. It is accepted at any position. Any detected sync counts as the previous sync, accepted or not.
- R5: A sync that passes neither test is ignored. The frame-start schedule keeps its old phase.
- R6: `locked` rises after the first coincidence.
- R7: `locked` falls at the LOSS_FRAMES-th (default 61) consecutive frame-start period that has no coincidence. The missed-frame count saturates there, and `locked` stays low until a new coincidence.
- R8: A coincidence clears the missed-frame count, so the next loss needs a full new run of LOSS_FRAMES frames without a coincidence.
- R9: A synchronous active-high `rst` clears `locked`, `frame_start` and `realign` and returns the position counter to 0. It also clears the missed-frame count and forgets the previous sync.
- R10: `realign` pulses together with `frame_start` only when an accepted sync lands at a nonzero position. An accepted sync at position 0 gives no `realign`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle enable marking each bit period |
| sync_det | input | 1 | Sync pattern seen in this bit period (qualified by bit_en) |
| frame_start | output | 1 | One-clock strobe for a position-0 period |
| locked | output | 1 | Lock indication |
| realign | output | 1 | One-clock pulse when an accepted sync shifts the frame phase |

## Verification
The assertions assume that `sync_det` means something only while `bit_en` is high. They also assume that reset is held for at least one clock edge before the first enable. The stimulus keeps to this: it asserts reset at the start of each scenario and moves inputs only between clock edges. Most stimulus uses `bit_en` high every clock. One section holds `bit_en` low with `sync_det` high to show that such clocks have no effect. The sweeps place a single sync at every frame position and second syncs at gaps from FRAME_LEN-3 to FRAME_LEN+3, with the second sync always outside the position window.

// File: rtl/frame_sync_guard.sv
module frame_sync_guard #(
  parameter int FRAME_LEN   = 588,
  parameter int COIN_TOL    = 1,
  parameter int WIN_TOL     = 6,
  parameter int LOSS_FRAMES = 61
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic sync_det,
  output logic frame_start,
  output logic locked,
  output logic realign
);

  localparam int GAP_MAX = FRAME_LEN + COIN_TOL + 1;
  localparam int PW = $clog2(FRAME_LEN);
  localparam int GW = $clog2(GAP_MAX + 1);
  localparam int MW = $clog2(LOSS_FRAMES + 1);

  logic [PW-1:0] pos;
  logic [GW-1:0] gap;
  logic [MW-1:0] miss;

  wire in_win  = (pos <= PW'(WIN_TOL)) || (pos >= PW'(FRAME_LEN - WIN_TOL));
  wire coin    = sync_det && (gap >= GW'(FRAME_LEN - COIN_TOL)) &&
                 (gap <= GW'(FRAME_LEN + COIN_TOL));
  wire accept  = sync_det && (coin || in_win);
  wire at_zero = accept || (pos == '0);
  wire wrap    = pos == PW'(FRAME_LEN - 1);
  wire [MW-1:0] miss_inc = (miss == MW'(LOSS_FRAMES)) ? miss : miss + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos         <= '0;
      gap         <= GW'(GAP_MAX);
      miss        <= '0;
      locked      <= 1'b0;
      frame_start <= 1'b0;
      realign     <= 1'b0;
    end else begin
      frame_start <= bit_en && at_zero;
      realign     <= bit_en && accept && (pos != '0);
      if (bit_en) begin
        pos <= accept ? PW'(1) : (wrap ? '0 : pos + 1'b1);
        gap <= sync_det ? GW'(1) : ((gap == GW'(GAP_MAX)) ? gap : gap + 1'b1);
        if (coin) begin
          miss   <= '0;
          locked <= 1'b1;
        end else if (at_zero) begin
          miss <= miss_inc;
          if (miss_inc == MW'(LOSS_FRAMES)) locked <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/frame_sync_guard_chk.sv
module frame_sync_guard_chk #(
  parameter int FRAME_LEN   = 588,
  parameter int LOSS_FRAMES = 61,
  localparam int PW = $clog2(FRAME_LEN),
  localparam int MW = $clog2(LOSS_FRAMES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_en,
  input logic          sync_det,
  input logic          frame_start,
  input logic          locked,
  input logic          realign,
  input logic [PW-1:0] pos,
  input logic [MW-1:0] miss
);

  assert_pos_range_R1: assert property (@(posedge clk) disable iff (rst)
    int'(pos) < FRAME_LEN);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_en) |-> (!frame_start && !realign));

  assert_realign_from_sync_R3: assert property (@(posedge clk) disable iff (rst)
    realign |-> $past(sync_det && bit_en));

  assert_lock_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(sync_det && bit_en));

  assert_lock_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> frame_start);

  assert_miss_sat_R7: assert property (@(posedge clk) disable iff (rst)
    int'(miss) <= LOSS_FRAMES);

  assert_realign_frame_R10: assert property (@(posedge clk) disable iff (rst)
    realign |-> frame_start);

endmodule

bind frame_sync_guard frame_sync_guard_chk #(
  .FRAME_LEN(FRAME_LEN), .LOSS_FRAMES(LOSS_FRAMES)
) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .sync_det(sync_det),
  .frame_start(frame_start), .locked(locked), .realign(realign),
  .pos(pos), .miss(miss)
);

// File: tb/frame_sync_guard_tb.sv
module frame_sync_guard_tb;
  localparam int L    = 48;
  localparam int WIN  = 6;
  localparam int LOSS = 61;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic sync_det = 1'b0;
  logic frame_start, locked, realign;

  int checks = 0;
  int fails  = 0;
  int ph     = 0;

  always #10 clk = ~clk;

  frame_sync_guard #(.FRAME_LEN(L), .COIN_TOL(1), .WIN_TOL(WIN), .LOSS_FRAMES(LOSS)) u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .sync_det(sync_det),
    .frame_start(frame_start), .locked(locked), .realign(realign));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic en, input logic s);
    bit_en = en; sync_det = s;
    @(posedge clk); #1;
    bit_en = 1'b0; sync_det = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_en = 1'b0; sync_det = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0; ph = 0;
  endtask

  task automatic free(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      tick(1'b1, 1'b0);
      if (frame_start !== (ph == 0)) bad++;
      ph = (ph + 1) % L;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic go(input int p, input string req);
    free((p - ph + L) % L, req);
  endtask

  task automatic pulse(input bit acc, input string req);
    bit efs, erl;
    efs = acc || (ph == 0);
    erl = acc && (ph != 0);
    tick(1'b1, 1'b1);
    chk(frame_start === efs, {req, " frame_start"}, frame_start, efs);
    chk(realign === erl, {req, " realign"}, realign, erl);
    ph = acc ? 1 : (ph + 1) % L;
  endtask

  task automatic acquire(input string req);
    do_reset();
    go(20, req);
    pulse(1'b0, req);
    free(L - 1, req);
    pulse(1'b1, req);
    chk(locked === 1'b1, {req, " lock acquired"}, locked, 1);
  endtask

  task automatic loss_run(input string req);
    int fell_at = 0;
    int bad = 0;
    for (int k = 1; k <= LOSS + 3; k++) begin
      free((L - ph) % L, req);
      tick(1'b1, 1'b0);
      ph = 1;
      if (frame_start !== 1'b1) bad++;
      if (locked === 1'b0 && fell_at == 0) fell_at = k;
      if (locked !== (k < LOSS)) bad++;
    end
    chk(fell_at == LOSS, {req, " lock lost at frame"}, fell_at, LOSS);
    chk(bad == 0, {req, " lock per frame"}, bad, 0);
  endtask

  initial begin
    #4000000;
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R9 reset state
    do_reset();
    chk(locked === 1'b0, "R9 locked after reset", locked, 0);
    chk(frame_start === 1'b0, "R9 frame_start after reset", frame_start, 0);
    chk(realign === 1'b0, "R9 realign after reset", realign, 0);

    // R1 free running schedule
    free(3 * L, "R1 free run");

    // R2 enable low: nothing moves
    begin
      int bad = 0;
      go(5, "R2 setup");
      for (int i = 0; i < 10; i++) begin
        tick(1'b0, 1'b1);
        if (frame_start !== 1'b0 || realign !== 1'b0) bad++;
      end
      chk(bad == 0, "R2 idle clocks quiet", bad, 0);
      free(2 * L, "R2 schedule unchanged");
    end

    // R3 / R5 / R10: single sync at every position
    for (int d = 0; d < L; d++) begin
      bit acc;
      acc = (d <= WIN) || (d >= L - WIN);
      do_reset();
      go(d, "R3 setup");
      pulse(acc, acc ? "R3 window accept" : "R5 outside ignored");
      chk(locked === 1'b0, "R6 no lock from window sync", locked, 0);
      free(L, acc ? "R3 new phase" : "R5 phase kept");
    end

    // R4 / R6: coincidence gap sweep, second sync outside window
    for (int g = L - 3; g <= L + 3; g++) begin
      bit acc;
      acc = (g >= L - 1) && (g <= L + 1);
      do_reset();
      go(20, "R4 setup");
      pulse(1'b0, "R5 first sync ignored");
      free(g - 1, "R4 gap");
      pulse(acc, acc ? "R4 coincidence accept" : "R4 gap rejected");
      chk(locked === acc, "R6 lock after gap", locked, acc);
      free(L, "R4 following phase");
    end

    // R7 lock loss and saturation
    acquire("R6");
    loss_run("R7");
    free(5 * L, "R7 after loss");
    chk(locked === 1'b0, "R7 stays unlocked", locked, 0);

    // R8 coincidence clears missed count
    acquire("R8");
    free(40 * L, "R8 run");
    chk(locked === 1'b1, "R8 still locked", locked, 1);
    go(0, "R8 align");
    pulse(1'b1, "R8 window sync");
    free(L - 1, "R8 gap");
    pulse(1'b1, "R8 coincidence");
    loss_run("R8");

    // R9 reset while locked
    acquire("R9");
    do_reset();
    chk(locked === 1'b0, "R9 reset clears lock", locked, 0);
    free(L, "R9 phase from reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule